// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one accepted READ or WRITE command into the column address for every beat of the burst that follows. A mode word, loaded while no burst is running, sets the burst length, the beat ordering, the CAS latency and the write-burst behaviour. The block decodes that word and keeps only legal settings. When a start strobe arrives, the block captures the starting column. From the next clock on, it puts out one column per cycle and raises a last-beat flag on the final beat.

Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size. The block is selected by the upper column bits, and the low bits wrap around inside it. The low bits either count upward or follow an XOR pattern. A full-page sequential burst walks through the entire 1024-column page, wraps from the top column to column 0, and keeps going until the terminate input stops it. The decoded CAS latency and write-burst mode are provided as outputs for the command and data-path logic. Any mode word that uses a reserved code is refused and raises an error flag.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the outputs are as follows: `beat_valid` = 0, `mode_err` = 0, `cas_lat` = 2 and `write_single` = 0. The active mode is a one-beat sequential burst.
- R2: Mode word fields are decoded as follows:
  - bits [2:0] give the length: 000→1, 001→2, 010→4, 011→8, 111→full page.
  - bit 3 gives the ordering: 0 = sequential, 1 = interleaved.
  - bits [6:4] give the latency: 010→2, 011→3.
  - bits [8:7] must be 00.
  - bit 9 = 1 makes each write a single-location access.
  
  `cas_lat` and `write_single` show the stored word from the cycle after a successful load.
- R3: A load that uses any other length or latency code, non-zero bits [8:7], or full page with bit 3 = 1 is not stored, and `mode_err` is 1 on the next cycle. A legal load, accepted while idle, clears `mode_err`.
- R4: A load requested while a burst is active is ignored, and `mode_err` is 1 on the next cycle.
- R5: A `start` sampled while idle, with `terminate` low, makes `beat_valid` go high on the next cycle with `beat_col` equal to `start_col`. One beat follows on each clock after that.
- R6: In sequential mode with length BL = 2^k, the low k bits of beat n are (start + n) mod BL. Column bits [9:k] keep their starting value.
- R7: In interleaved mode, the low k bits of beat n are start XOR n, and the upper bits keep their starting value.
- R8: `beat_last` is 1 on beat BL−1 of a fixed-length burst. `beat_valid` is 0 on the following cycle.
- R9: A full-page burst increments the whole column and wraps from 1023 to 0. `beat_last` is never raised, and the burst runs until it is terminated.
- R10: `terminate` sampled high makes `beat_valid` 0 on the next cycle. A `start` in the same cycle is ignored.
- R11: When `write_single` is 1, a start with `is_write` = 1 produces exactly one beat with `beat_last` = 1. When it is 0, writes use the programmed length.
- R12: A `start` sampled while a burst is active is ignored. The running burst keeps its sequence and adds no extra beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Request to store `mode_word` |
| mode_word | input | 12 | Mode word to program |
| start | input | 1 | Accept a READ/WRITE and begin a burst |
| start_col | input | 10 | Starting column of the burst |
| is_write | input | 1 | The accepted command is a WRITE |
| terminate | input | 1 | End the current burst |
| beat_valid | output | 1 | A beat column is present this cycle |
| beat_col | output | 10 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Last load attempt was refused |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| write_single | output | 1 | Writes are single-location accesses |

## Verification
The bench starts bursts whose start column sits in the middle of the aligned block, so that the wrap happens inside the block. A design that carried into bit k would leave the block, and a design that used addition in interleaved mode would produce 5,6,7,0 where 5,4,7,6 is expected. A full-page burst is started just below column 1023 to expose a design that saturates or stops at the page end rather than wrapping. Reserved codes are loaded one at a time to catch a decoder that accepts page-plus-interleave or a non-zero operating mode. Mode loads and extra start strobes arrive during live bursts, and terminate coincides with a start, which exposes a design that lets either one disturb the running sequence or adds extra beats.

// File: rtl/sdram_bseq_pkg.sv
package sdram_bseq_pkg;

   localparam int LEN_LOG_W = 4;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_XOR = 1'b1
   } beat_order_e;

   typedef struct packed {
      logic                 legal;
      logic                 page;
      beat_order_e          order;
      logic [LEN_LOG_W-1:0] len_log;
      logic [1:0]           cas;
      logic                 wr_single;
   } mode_fields_t;

endpackage

// File: rtl/sdram_bseq_mode_dec.sv
module sdram_bseq_mode_dec
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 12
) (
   input  logic [MODE_W-1:0] word_i,
   output mode_fields_t      fields_o
);

   localparam logic [LEN_LOG_W-1:0] PAGE_LOG = LEN_LOG_W'(COL_W);

   logic len_ok;
   logic cas_ok;
   logic op_ok;

   always_comb begin
      fields_o           = '0;
      fields_o.order     = beat_order_e'(word_i[3]);
      fields_o.wr_single = word_i[9];
      len_ok             = 1'b1;
      unique case (word_i[2:0])
         3'b000:  fields_o.len_log = LEN_LOG_W'(0);
         3'b001:  fields_o.len_log = LEN_LOG_W'(1);
         3'b010:  fields_o.len_log = LEN_LOG_W'(2);
         3'b011:  fields_o.len_log = LEN_LOG_W'(3);
         3'b111: begin
            fields_o.len_log = PAGE_LOG;
            fields_o.page    = 1'b1;
            len_ok           = ~word_i[3];
         end
         default: len_ok = 1'b0;
      endcase
      cas_ok = 1'b1;
      unique case (word_i[6:4])
         3'b010:  fields_o.cas = 2'd2;
         3'b011:  fields_o.cas = 2'd3;
         default: begin
            fields_o.cas = 2'd2;
            cas_ok       = 1'b0;
         end
      endcase
      op_ok          = (word_i[8:7] == 2'b00);
      fields_o.legal = len_ok & cas_ok & op_ok;
   end

endmodule

// File: rtl/sdram_bseq_addr.sv
module sdram_bseq_addr
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter bit XOR_EN = 1'b1
) (
   input  logic [COL_W-1:0]     base_i,
   input  logic [COL_W-1:0]     idx_i,
   input  logic [LEN_LOG_W-1:0] len_log_i,
   input  beat_order_e          order_i,
   output logic [COL_W-1:0]     col_o
);

   logic [COL_W-1:0] sum_w;
   logic [COL_W-1:0] low_w;
   logic [COL_W-1:0] wrap_mask;

   assign sum_w = base_i + idx_i;

   generate
      if (XOR_EN) begin : g_xor_order
         logic [COL_W-1:0] xor_w;
         assign xor_w = base_i ^ idx_i;
         assign low_w = (order_i == ORD_XOR) ? xor_w : sum_w;
      end else begin : g_seq_only
         assign low_w = sum_w;
      end
   endgenerate

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      assign wrap_mask[b] = (LEN_LOG_W'(b) < len_log_i);
      assign col_o[b]     = wrap_mask[b] ? low_w[b] : base_i[b];
   end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 12,
   parameter bit XOR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_load,
   input  logic [MODE_W-1:0] mode_word,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic              is_write,
   input  logic              terminate,
   output logic              beat_valid,
   output logic [COL_W-1:0]  beat_col,
   output logic              beat_last,
   output logic              mode_err,
   output logic [1:0]        cas_lat,
   output logic              write_single
);

   localparam mode_fields_t RESET_MODE = '{
      legal: 1'b1, page: 1'b0, order: ORD_SEQ,
      len_log: '0, cas: 2'd2, wr_single: 1'b0};

   if (COL_W < 3 || COL_W >= (1 << LEN_LOG_W)) begin : g_bad_col_w
      $error("COL_W out of supported range");
   end
   if (MODE_W < 10) begin : g_bad_mode_w
      $error("MODE_W too narrow for the mode fields");
   end

   mode_fields_t         dec_f;
   mode_fields_t         mode_q;
   logic                 err_q;
   logic                 active_q;
   logic [COL_W-1:0]     base_q;
   logic [COL_W-1:0]     idx_q;
   logic [LEN_LOG_W-1:0] len_q;
   logic                 page_q;
   beat_order_e          order_q;
   logic [COL_W-1:0]     end_idx;
   logic                 at_end;
   logic                 take_start;
   logic                 single_wr;

   sdram_bseq_mode_dec #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dec (
      .word_i   (mode_word),
      .fields_o (dec_f)
   );

   sdram_bseq_addr #(.COL_W(COL_W), .XOR_EN(XOR_EN)) u_addr (
      .base_i    (base_q),
      .idx_i     (idx_q),
      .len_log_i (len_q),
      .order_i   (order_q),
      .col_o     (beat_col)
   );

   assign end_idx    = ~({COL_W{1'b1}} << len_q);
   assign at_end     = active_q && !page_q && (idx_q == end_idx);
   assign take_start = start && !active_q && !terminate;
   assign single_wr  = is_write && mode_q.wr_single;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RESET_MODE;
         err_q  <= 1'b0;
      end else if (mode_load) begin
         if (active_q || !dec_f.legal) begin
            err_q <= 1'b1;
         end else begin
            mode_q <= dec_f;
            err_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         idx_q    <= '0;
         len_q    <= '0;
         page_q   <= 1'b0;
         order_q  <= ORD_SEQ;
      end else if (terminate) begin
         active_q <= 1'b0;
      end else if (take_start) begin
         active_q <= 1'b1;
         base_q   <= start_col;
         idx_q    <= '0;
         len_q    <= single_wr ? '0 : mode_q.len_log;
         page_q   <= mode_q.page && !single_wr;
         order_q  <= mode_q.order;
      end else if (active_q) begin
         if (at_end) active_q <= 1'b0;
         else        idx_q    <= idx_q + 1'b1;
      end
   end

   assign beat_valid   = active_q;
   assign beat_last    = at_end;
   assign mode_err     = err_q;
   assign cas_lat      = mode_q.cas;
   assign write_single = mode_q.wr_single;

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk
   import sdram_bseq_pkg::*;
#(
   parameter int COL_W = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode_load,
   input logic                 terminate,
   input logic                 beat_valid,
   input logic                 beat_last,
   input logic [COL_W-1:0]     beat_col,
   input logic                 mode_err,
   input logic [1:0]           cas_lat,
   input logic                 write_single,
   input logic [LEN_LOG_W-1:0] len_q,
   input logic                 page_q,
   input logic                 order_q
);

   logic [COL_W-1:0] blk_mask;
   assign blk_mask = ~({COL_W{1'b1}} << len_q);

   AST_CAS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_lat == 2'd2) || (cas_lat == 2'd3)); // R2

   AST_LOAD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      mode_load && beat_valid |=> mode_err); // R4

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |=> $stable(cas_lat) && $stable(write_single)); // R4

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && $past(beat_valid) |->
         (((beat_col ^ $past(beat_col)) & ~blk_mask) == '0)); // R6

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && $past(beat_valid) && !order_q |->
         ((beat_col & blk_mask) == (($past(beat_col) + 1'b1) & blk_mask))); // R9

   AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && beat_last |=> !beat_valid); // R8

   AST_TERM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      terminate |=> !beat_valid); // R10

   AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && page_q |-> !beat_last); // R9

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_load    (mode_load),
   .terminate    (terminate),
   .beat_valid   (beat_valid),
   .beat_last    (beat_last),
   .beat_col     (beat_col),
   .mode_err     (mode_err),
   .cas_lat      (cas_lat),
   .write_single (write_single),
   .len_q        (len_q),
   .page_q       (page_q),
   .order_q      (order_q)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;

   typedef struct {
      logic [9:0] col;
      logic       last;
      string      req;
   } beat_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_load = 1'b0;
   logic [11:0] mode_word = '0;
   logic       start = 1'b0;
   logic [9:0] start_col = '0;
   logic       is_write = 1'b0;
   logic       terminate = 1'b0;
   logic       beat_valid;
   logic [9:0] beat_col;
   logic       beat_last;
   logic       mode_err;
   logic [1:0] cas_lat;
   logic       write_single;

   beat_t exp_q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sdram_burst_seq dut (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
      .start(start), .start_col(start_col), .is_write(is_write),
      .terminate(terminate), .beat_valid(beat_valid), .beat_col(beat_col),
      .beat_last(beat_last), .mode_err(mode_err), .cas_lat(cas_lat),
      .write_single(write_single));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] ecol(logic [9:0] s, int n, int len, bit ilv);
      logic [9:0] m;
      logic [9:0] low;
      m   = (10'h1 << len) - 10'h1;
      low = ilv ? (s ^ 10'(n)) : (s + 10'(n));
      return (s & ~m) | (low & m);
   endfunction

   // monitor: pop and compare each beat
   always @(negedge clk) begin
      if (rst_n && beat_valid && !done) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 unexpected beat: actual %0h expected none", beat_col);
         end else begin
            beat_t e;
            e = exp_q.pop_front();
            check(e.req, {22'd0, beat_col}, {22'd0, e.col}, "beat column");
            check(e.req, {31'd0, beat_last}, {31'd0, e.last}, "last flag");
         end
      end
   end

   task automatic wait_idle(input string req);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk); #1;
         if (exp_q.size() == 0 && !beat_valid) break;
      end
      check(req, exp_q.size(), 0, "beats still owed");
   endtask

   task automatic load(input logic [11:0] w);
      @(negedge clk);
      mode_load = 1'b1; mode_word = w;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   // drive one burst; nbeats expected, term_at>0 terminates after that many beats
   task automatic burst(input logic [9:0] s, input bit wr, input int nbeats,
                        input int len, input bit ilv, input bit page,
                        input int term_at, input string req);
      for (int k = 0; k < nbeats; k++) begin
         beat_t b;
         b.col  = ecol(s, k, len, ilv);
         b.last = !page && (k == (1 << len) - 1);
         b.req  = req;
         exp_q.push_back(b);
      end
      @(negedge clk);
      start = 1'b1; start_col = s; is_write = wr;
      @(negedge clk);
      start = 1'b0; is_write = 1'b0;
      if (term_at > 0) begin
         repeat (term_at - 1) @(negedge clk);
         terminate = 1'b1;
         @(negedge clk);
         terminate = 1'b0;
      end
      wait_idle(req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", beat_valid, 0, "valid after reset");
      check("R1", mode_err, 0, "error after reset");
      check("R1", cas_lat, 2, "latency after reset");
      check("R1", write_single, 0, "write mode after reset");
      // R1 R5 default one-beat burst
      burst(10'h155, 1'b0, 1, 0, 1'b0, 1'b0, 0, "R5");
      // R2 length 4 sequential, latency 3
      load(12'h032);
      check("R2", cas_lat, 3, "latency 3 decode");
      check("R2", mode_err, 0, "legal load");
      burst(10'h2A6, 1'b0, 4, 2, 1'b0, 1'b0, 0, "R6");
      // R7 R8 length 8 interleaved, latency 2
      load(12'h02B);
      check("R2", cas_lat, 2, "latency 2 decode");
      burst(10'h0F5, 1'b0, 8, 3, 1'b1, 1'b0, 0, "R7");
      // R3 reserved codes
      load(12'h024);
      check("R3", mode_err, 1, "reserved length");
      load(12'h013);
      check("R3", mode_err, 1, "reserved latency");
      check("R3", cas_lat, 2, "latency kept");
      load(12'h0A3);
      check("R3", mode_err, 1, "reserved op mode");
      load(12'h02F);
      check("R3", mode_err, 1, "page with interleave");
      burst(10'h3F9, 1'b0, 8, 3, 1'b1, 1'b0, 0, "R3");
      // R3 R2 legal load clears error: page, latency 3, single writes
      load(12'h237);
      check("R3", mode_err, 0, "error cleared");
      check("R2", write_single, 1, "write single decode");
      // R9 full page wrap, stopped by terminate
      burst(10'h3FD, 1'b0, 6, 10, 1'b0, 1'b1, 6, "R9");
      // R4 load during active page burst
      exp_q.push_back('{10'h010, 1'b0, "R4"});
      exp_q.push_back('{10'h011, 1'b0, "R4"});
      exp_q.push_back('{10'h012, 1'b0, "R4"});
      @(negedge clk);
      start = 1'b1; start_col = 10'h010;
      @(negedge clk);
      start = 1'b0; mode_load = 1'b1; mode_word = 12'h022;
      @(negedge clk);
      mode_load = 1'b0;
      check("R4", mode_err, 1, "load while active flagged");
      check("R4", cas_lat, 3, "latency unchanged");
      @(negedge clk);
      terminate = 1'b1;
      @(negedge clk);
      terminate = 1'b0;
      wait_idle("R4");
      // R11 single-location write
      burst(10'h123, 1'b1, 1, 0, 1'b0, 1'b0, 0, "R11");
      // R6 R11 length 2 sequential, writes follow length
      load(12'h021);
      check("R11", write_single, 0, "write single off");
      burst(10'h3FF, 1'b0, 2, 1, 1'b0, 1'b0, 0, "R6");
      burst(10'h040, 1'b1, 2, 1, 1'b0, 1'b0, 0, "R11");
      // R12 start during active burst is ignored
      load(12'h023);
      for (int k = 0; k < 8; k++)
         exp_q.push_back('{ecol(10'h10E, k, 3, 1'b0), k == 7, "R12"});
      @(negedge clk);
      start = 1'b1; start_col = 10'h10E;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1; start_col = 10'h000;
      @(negedge clk);
      start = 1'b0;
      wait_idle("R12");
      repeat (2) @(negedge clk);
      check("R12", beat_valid, 0, "no extra burst");
      // R10 terminate with start from idle
      @(negedge clk);
      start = 1'b1; terminate = 1'b1; start_col = 10'h200;
      @(negedge clk);
      start = 1'b0; terminate = 1'b0;
      check("R10", beat_valid, 0, "start ignored under terminate");
      @(negedge clk);
      check("R10", beat_valid, 0, "still idle");
      // R10 interleaved burst cut after 2 beats
      load(12'h02A);
      burst(10'h083, 1'b0, 2, 2, 1'b1, 1'b0, 2, "R10");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule